// File: doc/BRIEF.md
# Branch Prediction Sanity Checker

This block sits at the end of the decode stage and checks every predicted-taken mark that fetch attaches to a decoded instruction. A prediction is legitimate only on a conditional branch or a jump. When a valid lane carries a taken prediction but decodes as an ordinary instruction, the predictor has made a false hit. The block then requests a pipeline flush and steers fetch back to that instruction. It also raises a flag telling fetch to ignore the predictor for the first prediction of the replay, so the same false hit cannot happen again.

The decode stage can present several lanes per cycle, with lane 0 the oldest. When more than one lane is offending, only the oldest one counts. That lane and every younger lane are marked for discard. Older lanes are left alone. All outputs are registered. The flush and discard mask last for one cycle per event. The skip flag stays high until fetch accepts the refetched address.

Top module: `pred_sanity_top`

## Requirements
- R1: A lane is offending when it is valid, has its predicted-taken bit set, and has a class code of 0. The class codes are 0 = ordinary, 1 = conditional branch, 2 = direct jump and 3 = indirect jump.
- R2: An offending lane presented in cycle N raises `flushReq` in cycle N+1 only. `flushReq` is never high on two consecutive cycles.
- R3: In the flush cycle, `redirectPc` equals the PC of the lowest-numbered offending lane. It holds that value until the next flush event.
- R4: In the flush cycle, bit i of `laneKill` is set for every lane i at or above the offending lane and clear below it. Outside a flush cycle, `laneKill` is zero.
- R5: `skipFirstPred` rises in the same cycle as `flushReq`.
- R6: `skipFirstPred` falls in the cycle after `fetchAccept` is high with `fetchPc` equal to `redirectPc`. An accept at any other PC leaves it set.
- R7: Valid lanes that carry no prediction, predicted lanes of class 1 to 3, and invalid lanes cause no flush, no discard and no change of `redirectPc` or `skipFirstPred`.
- R8: Lanes presented during a cycle in which `flushReq` is high are ignored, because they belong to the flushed path.
- R9: A new event while the skip flag is already set reloads `redirectPc` and keeps the flag set. If it coincides with a matching accept, the event wins.
- R10: While `rstN` is low, `flushReq`, `laneKill`, `skipFirstPred` and `redirectPc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| laneValid | input | LANES | Per-lane decoded instruction valid |
| lanePc | input | LANES*PC_W | Per-lane PC, lane i at bits [i*PC_W +: PC_W] |
| lanePredTaken | input | LANES | Per-lane predicted-taken mark from fetch |
| laneClass | input | 2*LANES | Per-lane control class, lane i at bits [2i +: 2] |
| fetchAccept | input | 1 | Fetch accepted a request this cycle |
| fetchPc | input | PC_W | Address fetch accepted |
| flushReq | output | 1 | One-cycle pipeline flush request |
| laneKill | output | LANES | Lanes to discard in the flush cycle |
| redirectPc | output | PC_W | Address fetch must restart from |
| skipFirstPred | output | 1 | Fetch must ignore its first prediction |

## Verification
The block has one register stage, so lanes and fetch handshakes driven in one cycle affect `flushReq`, `laneKill`, `redirectPc` and `skipFirstPred` on the next clock edge. Clearing the skip flag also takes exactly one edge. The bench drives each stimulus on a falling edge and compares all four outputs on the following falling edge. That compare point falls exactly one rising edge later. The vector order is chosen so that the cycle after each flush is itself a stimulus whose lanes must be ignored. This lets the same one-edge rule cover the pulse width and the blanking behaviour.

// File: rtl/pred_sanity_pkg.sv
package pred_sanity_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_JUMP   = 2'd2,
    CLS_JUMPR  = 2'd3
  } ctrl_class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic arm;   // capture a new redirect event
    logic drop;  // fetch accepted the replay address
  } guard_strobe_t;

endpackage

// File: rtl/pred_sanity_ctrl.sv
module pred_sanity_ctrl
  import pred_sanity_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IDX_W = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   laneValid,
  input  logic [LANES-1:0]   lanePredTaken,
  input  logic [2*LANES-1:0] laneClass,
  input  logic               fetchAccept,
  input  logic               pcMatch,
  output logic               flushReq,
  output logic [IDX_W-1:0]   laneSel,
  output guard_strobe_t      strobe
);

  logic [LANES-1:0] offend;
  logic             found;
  logic             hit;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      offend[i] = laneValid[i] && lanePredTaken[i] &&
                  (ctrl_class_e'(laneClass[2*i +: 2]) == CLS_OTHER);
    end
  end

  // oldest lane (lowest index) wins
  always_comb begin
    laneSel = '0;
    found   = 1'b0;
    for (int i = LANES-1; i >= 0; i--) begin
      if (offend[i]) begin
        laneSel = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  // lanes seen during a flush cycle are on the dead path
  assign hit         = found && !flushReq;
  assign strobe.arm  = hit;
  assign strobe.drop = fetchAccept && pcMatch && !hit;

  always_ff @(posedge clk) begin
    if (!rstN) flushReq <= 1'b0;
    else       flushReq <= hit;
  end

  p_flush_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !flushReq);

  p_flush_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((offend != '0) && !flushReq) |=> flushReq);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (offend == '0) |=> !flushReq);

  p_blank_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !strobe.arm);

endmodule

// File: rtl/pred_sanity_dp.sv
module pred_sanity_dp
  import pred_sanity_pkg::*;
#(
  parameter int LANES = 2,
  parameter int PC_W  = 32,
  parameter int IDX_W = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANES*PC_W-1:0] lanePc,
  input  logic [IDX_W-1:0]      laneSel,
  input  guard_strobe_t         strobe,
  input  logic [PC_W-1:0]       fetchPc,
  output logic [PC_W-1:0]       redirectPc,
  output logic [LANES-1:0]      laneKill,
  output logic                  skipFirstPred,
  output logic                  pcMatch
);

  logic [PC_W-1:0]  selPc;
  logic [LANES-1:0] newKill;

  assign selPc   = lanePc[int'(laneSel)*PC_W +: PC_W];
  assign pcMatch = (fetchPc == redirectPc);

  for (genvar i = 0; i < LANES; i++) begin : g_kill
    assign newKill[i] = (i >= int'(laneSel));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectPc    <= '0;
      laneKill      <= '0;
      skipFirstPred <= 1'b0;
    end else begin
      laneKill <= strobe.arm ? newKill : '0;
      if (strobe.arm) begin
        redirectPc    <= selPc;
        skipFirstPred <= 1'b1;
      end else if (strobe.drop) begin
        skipFirstPred <= 1'b0;
      end
    end
  end

  p_skip_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arm |=> skipFirstPred);

  p_skip_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (skipFirstPred && strobe.drop) |=> !skipFirstPred);

  p_redirect_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.arm |=> $stable(redirectPc));

  p_kill_youngest_r4: assert property (@(posedge clk) disable iff (!rstN)
    (laneKill != '0) |-> laneKill[LANES-1]);

endmodule

// File: rtl/pred_sanity_top.sv
module pred_sanity_top
  import pred_sanity_pkg::*;
#(
  parameter int LANES = 2,
  parameter int PC_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANES-1:0]      laneValid,
  input  logic [LANES*PC_W-1:0] lanePc,
  input  logic [LANES-1:0]      lanePredTaken,
  input  logic [2*LANES-1:0]    laneClass,
  input  logic                  fetchAccept,
  input  logic [PC_W-1:0]       fetchPc,
  output logic                  flushReq,
  output logic [LANES-1:0]      laneKill,
  output logic [PC_W-1:0]       redirectPc,
  output logic                  skipFirstPred
);

  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  guard_strobe_t    strobe;
  logic [IDX_W-1:0] laneSel;
  logic             pcMatch;

  pred_sanity_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .laneValid(laneValid),
    .lanePredTaken(lanePredTaken), .laneClass(laneClass),
    .fetchAccept(fetchAccept), .pcMatch(pcMatch),
    .flushReq(flushReq), .laneSel(laneSel), .strobe(strobe)
  );

  pred_sanity_dp #(.LANES(LANES), .PC_W(PC_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .lanePc(lanePc), .laneSel(laneSel),
    .strobe(strobe), .fetchPc(fetchPc), .redirectPc(redirectPc),
    .laneKill(laneKill), .skipFirstPred(skipFirstPred), .pcMatch(pcMatch)
  );

endmodule

// File: tb/pred_sanity_tb.sv
module pred_sanity_top_tb_top;

  localparam int LANES = 2;
  localparam int PC_W  = 32;
  localparam int NV    = 13;

  typedef struct packed {
    logic [1:0]  v;
    logic [1:0]  p;
    logic [3:0]  cls;     // {lane1, lane0}
    logic [63:0] pcs;     // {lane1, lane0}
    logic        acc;
    logic [31:0] fpc;
    logic        eFlush;
    logic [1:0]  eKill;
    logic [31:0] ePc;
    logic        eSkip;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'b11, 2'b00, 4'b0000, {32'h14, 32'h10}, 1'b0, 32'h0,   1'b0, 2'b00, 32'h0,   1'b0}, // R7 no prediction
    '{2'b11, 2'b11, 4'b1001, {32'h24, 32'h20}, 1'b0, 32'h0,   1'b0, 2'b00, 32'h0,   1'b0}, // R7 predicted control
    '{2'b00, 2'b11, 4'b0000, {32'h34, 32'h30}, 1'b0, 32'h0,   1'b0, 2'b00, 32'h0,   1'b0}, // R7 invalid lanes
    '{2'b11, 2'b10, 4'b0001, {32'h104,32'h100},1'b0, 32'h0,   1'b1, 2'b10, 32'h104, 1'b1}, // R1 R3 R4 R5 lane1
    '{2'b11, 2'b01, 4'b0000, {32'h8c, 32'h88}, 1'b0, 32'h0,   1'b0, 2'b00, 32'h104, 1'b1}, // R8 R2 ignored
    '{2'b00, 2'b00, 4'b0000, {32'h0,  32'h0},  1'b1, 32'h200, 1'b0, 2'b00, 32'h104, 1'b1}, // R6 wrong pc
    '{2'b00, 2'b00, 4'b0000, {32'h0,  32'h0},  1'b1, 32'h104, 1'b0, 2'b00, 32'h104, 1'b0}, // R6 clear
    '{2'b11, 2'b11, 4'b0000, {32'h304,32'h300},1'b0, 32'h0,   1'b1, 2'b11, 32'h300, 1'b1}, // R3 oldest wins
    '{2'b00, 2'b00, 4'b0000, {32'h0,  32'h0},  1'b0, 32'h0,   1'b0, 2'b00, 32'h300, 1'b1}, // R2 one pulse
    '{2'b01, 2'b01, 4'b0000, {32'h0,  32'h400},1'b1, 32'h300, 1'b1, 2'b11, 32'h400, 1'b1}, // R9 event beats accept
    '{2'b00, 2'b00, 4'b0000, {32'h0,  32'h0},  1'b1, 32'h300, 1'b0, 2'b00, 32'h400, 1'b1}, // R9 old pc stale
    '{2'b00, 2'b00, 4'b0000, {32'h0,  32'h0},  1'b1, 32'h400, 1'b0, 2'b00, 32'h400, 1'b0}, // R6 clear
    '{2'b10, 2'b10, 4'b1100, {32'h504,32'h500},1'b0, 32'h0,   1'b0, 2'b00, 32'h400, 1'b0}  // R7 indirect jump
  };

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [LANES-1:0]      laneValid;
  logic [LANES*PC_W-1:0] lanePc;
  logic [LANES-1:0]      lanePredTaken;
  logic [2*LANES-1:0]    laneClass;
  logic                  fetchAccept;
  logic [PC_W-1:0]       fetchPc;
  logic                  flushReq;
  logic [LANES-1:0]      laneKill;
  logic [PC_W-1:0]       redirectPc;
  logic                  skipFirstPred;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  pred_sanity_top #(.LANES(LANES), .PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN), .laneValid(laneValid), .lanePc(lanePc),
    .lanePredTaken(lanePredTaken), .laneClass(laneClass),
    .fetchAccept(fetchAccept), .fetchPc(fetchPc), .flushReq(flushReq),
    .laneKill(laneKill), .redirectPc(redirectPc), .skipFirstPred(skipFirstPred)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic [1:0] p, input logic [3:0] c,
                       input logic [63:0] pcs, input logic a, input logic [31:0] f);
    laneValid = v; lanePredTaken = p; laneClass = c; lanePc = pcs;
    fetchAccept = a; fetchPc = f;
  endtask

  task automatic chkAll(input string tag, input logic fl, input logic [1:0] k,
                        input logic [31:0] pc, input logic sk);
    chk({tag, " flushReq"},      32'(flushReq),      32'(fl));
    chk({tag, " laneKill"},      32'(laneKill),      32'(k));
    chk({tag, " redirectPc"},    redirectPc,         pc);
    chk({tag, " skipFirstPred"}, 32'(skipFirstPred), 32'(sk));
  endtask

  initial begin
    #400000;
    nBad++; nChk++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(2'b11, 2'b11, 4'b0000, {32'h44, 32'h40}, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    chkAll("R10 reset", 1'b0, 2'b00, 32'h0, 1'b0);
    drive(2'b00, 2'b00, 4'b0000, 64'h0, 1'b0, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chkAll("R10 after reset", 1'b0, 2'b00, 32'h0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].v, VEC[k].p, VEC[k].cls, VEC[k].pcs, VEC[k].acc, VEC[k].fpc);
      @(negedge clk);
      chkAll($sformatf("vec%0d R1-table", k), VEC[k].eFlush, VEC[k].eKill,
             VEC[k].ePc, VEC[k].eSkip);
    end

    // R2/R8: offending lane held steady pulses every other cycle
    drive(2'b01, 2'b01, 4'b0000, {32'h0, 32'h500}, 1'b0, 32'h0);
    @(negedge clk);
    chk("R2 hold c1", 32'(flushReq), 32'd1);
    @(negedge clk);
    chk("R2 hold c2", 32'(flushReq), 32'd0);
    @(negedge clk);
    chk("R2 hold c3", 32'(flushReq), 32'd1);
    chk("R3 hold pc", redirectPc, 32'h500);
    drive(2'b00, 2'b00, 4'b0000, 64'h0, 1'b0, 32'h0);
    @(negedge clk);
    chk("R4 kill cleared", 32'(laneKill), 32'd0);

    // R10: reset mid-run clears a pending skip
    chk("R5 skip pending", 32'(skipFirstPred), 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    chkAll("R10 midrun", 1'b0, 2'b00, 32'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

endmodule